// File: doc/BRIEF.md
# Configurable GPIO Bank with Per-Pin Interrupt Detection

This block serves a bank of general-purpose pins. Every pin has its own 32-bit configuration word. The word sets the pin's direction by separately gating the input capture register, the output data register and the pad output enable. It also arms interrupt detection on that pin, using one of five trigger types: high level, low level, rising edge, falling edge or either edge. Pad inputs are resynchronised through two flops before they are used.

Software reaches the bank through a flat word-addressed register port. Reads are combinational from the address, and a write takes effect at the clock edge where `wr_en_i` is high. Each pin has a sticky interrupt flag, and software clears it by writing a 1 to the flag's bit. The bank also drives a single combined interrupt line.

Top module: `gpio_bank`

## Requirements
- R1: After reset every configuration word, the output register, `pad_o`, `pad_oe_o`, every interrupt flag and `irq_o` are 0.
- R2: A write to the output register (address 0x21) updates pin n only when bit 0 of pin n's configuration word is 1; otherwise the bit of `pad_o` and of the readback holds.
- R3: When bit 1 of a pin's configuration word is 1, the input register (address 0x20, read-only) takes the pad value; a change on `pad_i` shows in a read after the third rising edge and not after the second. When bit 1 is 0, the register holds.
- R4: `pad_oe_o[n]` is 1 exactly when bit 2 of pin n's configuration word is 1, from the edge after the write.
- R5: When bit 3 of a pin's configuration word is 0, that pin's interrupt flag never sets, whatever the pad does.
- R6: Type field bits 7:5 = 000 triggers on a high synchronised level, and 001 on a low one; while the level persists, a cleared flag sets again.
- R7: Type 010 triggers on a rising edge, 011 on a falling edge and 100 on either edge; a steady pad gives no trigger.
- R8: Type codes 101, 110 and 111 never set a flag.
- R9: Writing to the flag register (address 0x22) clears each flag whose data bit is 1 and leaves the others; if a trigger falls in the same cycle as a clear, the flag stays set.
- R10: `irq_o` is 1 whenever any pin's flag is set and 0 once all flags are clear.
- R11: Configuration bits 31:8 and bit 4 are storage only: they read back as written and affect no pin.
- R12: The address map is: addr[6:5]=00 selects pin addr[4:0]'s configuration word; 01 selects the data registers (index 0 input, 1 output, 2 flags); any other address reads 0.
- R13: With bits 0, 1 and 2 all set, the pin is bidirectional: the value the pin drives comes back through the pad and is returned by the input register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 7 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| pad_i | input | 32 | Pad input levels |
| pad_o | output | 32 | Pad output levels |
| pad_oe_o | output | 32 | Pad output enables |
| irq_o | output | 1 | OR of all interrupt flags |

## Verification
Two events can land on a pin's flag in the same cycle: a software write-1-to-clear and a fresh trigger from the detector. The bench holds a level-high pin asserted and clears its flag while the level is still present. The flag must read 1 afterwards, because the set takes priority. Once the pad falls and the synchronizer has settled, the same clear must leave the flag at 0.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned CFG_OUT_EN   = 0;
  localparam int unsigned CFG_IN_EN    = 1;
  localparam int unsigned CFG_OE       = 2;
  localparam int unsigned CFG_INT_EN   = 3;
  localparam int unsigned CFG_MODE_LSB = 5;
  localparam int unsigned MODE_W       = 3;

  localparam logic [1:0] GRP_CFG  = 2'd0;
  localparam logic [1:0] GRP_DATA = 2'd1;

  localparam int unsigned IDX_IN  = 0;
  localparam int unsigned IDX_OUT = 1;
  localparam int unsigned IDX_IRQ = 2;

  typedef enum logic [MODE_W-1:0] {
    IRQ_LVL_HI = 3'd0,
    IRQ_LVL_LO = 3'd1,
    IRQ_RISE   = 3'd2,
    IRQ_FALL   = 3'd3,
    IRQ_BOTH   = 3'd4
  } irq_mode_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] cur_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [WIDTH-1:0] meta_q, cur_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_i;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur_o  = cur_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 32,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned PIN_IDX_W = $clog2(NUM_PINS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [PIN_IDX_W-1:0] idx_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    cfg_o    [NUM_PINS],
  output logic [NUM_PINS-1:0]  out_en_o,
  output logic [NUM_PINS-1:0]  in_en_o,
  output logic [NUM_PINS-1:0]  oe_o,
  output logic [NUM_PINS-1:0]  int_en_o,
  output logic [MODE_W-1:0]    mode_o   [NUM_PINS]
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [DATA_W-1:0] cfg_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  cfg_q <= '0;
      else if (wr_i && idx_i == PIN_IDX_W'(i))      cfg_q <= wdata_i;
    end

    assign cfg_o[i]    = cfg_q;
    assign out_en_o[i] = cfg_q[CFG_OUT_EN];
    assign in_en_o[i]  = cfg_q[CFG_IN_EN];
    assign oe_o[i]     = cfg_q[CFG_OE];
    assign int_en_o[i] = cfg_q[CFG_INT_EN];
    assign mode_o[i]   = cfg_q[CFG_MODE_LSB +: MODE_W];
  end
endmodule

// File: rtl/gpio_data_regs.sv
module gpio_data_regs #(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] sync_i,
  input  logic [NUM_PINS-1:0] in_en_i,
  input  logic [NUM_PINS-1:0] out_en_i,
  input  logic                out_wr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] in_q_o,
  output logic [NUM_PINS-1:0] out_q_o
);
  logic [NUM_PINS-1:0] in_q, out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= '0;
      out_q <= '0;
    end else begin
      in_q <= (in_q & ~in_en_i) | (sync_i & in_en_i);
      if (out_wr_i) out_q <= (out_q & ~out_en_i) | (wdata_i & out_en_i);
    end
  end

  assign in_q_o  = in_q;
  assign out_q_o = out_q;
endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell
  import gpio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cur_i,
  input  logic              prev_i,
  input  logic              en_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              clr_i,
  output logic              flag_o
);
  logic hit, flag_q;

  always_comb begin
    unique case (mode_i)
      IRQ_LVL_HI: hit = cur_i;
      IRQ_LVL_LO: hit = ~cur_i;
      IRQ_RISE:   hit = cur_i & ~prev_i;
      IRQ_FALL:   hit = ~cur_i & prev_i;
      IRQ_BOTH:   hit = cur_i ^ prev_i;
      default:    hit = 1'b0;
    endcase
  end

  // set beats clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          flag_q <= 1'b0;
    else if (en_i && hit) flag_q <= 1'b1;
    else if (clr_i)       flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 32,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned PIN_IDX_W = $clog2(NUM_PINS),
  localparam int unsigned ADDR_W    = PIN_IDX_W + 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [NUM_PINS-1:0] pad_i,
  output logic [NUM_PINS-1:0] pad_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic                irq_o
);
  logic [1:0]           grp;
  logic [PIN_IDX_W-1:0] idx;
  logic                 cfg_wr, out_wr, irq_wr;

  logic [DATA_W-1:0]    cfg_q [NUM_PINS];
  logic [MODE_W-1:0]    mode  [NUM_PINS];
  logic [NUM_PINS-1:0]  out_en_vec, in_en_vec, oe_vec, int_en_vec;
  logic [NUM_PINS-1:0]  sync_q, prev_q, in_q, out_q, irq_flags;

  assign grp    = addr_i[ADDR_W-1 -: 2];
  assign idx    = addr_i[PIN_IDX_W-1:0];
  assign cfg_wr = wr_en_i && grp == GRP_CFG;
  assign out_wr = wr_en_i && grp == GRP_DATA && idx == PIN_IDX_W'(IDX_OUT);
  assign irq_wr = wr_en_i && grp == GRP_DATA && idx == PIN_IDX_W'(IDX_IRQ);

  gpio_cfg_regs #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (cfg_wr),
    .idx_i    (idx),
    .wdata_i  (wdata_i),
    .cfg_o    (cfg_q),
    .out_en_o (out_en_vec),
    .in_en_o  (in_en_vec),
    .oe_o     (oe_vec),
    .int_en_o (int_en_vec),
    .mode_o   (mode)
  );

  gpio_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pad_i),
    .cur_o   (sync_q),
    .prev_o  (prev_q)
  );

  gpio_data_regs #(.NUM_PINS(NUM_PINS)) u_data (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sync_i   (sync_q),
    .in_en_i  (in_en_vec),
    .out_en_i (out_en_vec),
    .out_wr_i (out_wr),
    .wdata_i  (wdata_i[NUM_PINS-1:0]),
    .in_q_o   (in_q),
    .out_q_o  (out_q)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_irq
    gpio_irq_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cur_i  (sync_q[i]),
      .prev_i (prev_q[i]),
      .en_i   (int_en_vec[i]),
      .mode_i (mode[i]),
      .clr_i  (irq_wr && wdata_i[i]),
      .flag_o (irq_flags[i])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (grp == GRP_CFG) begin
      rdata_o = cfg_q[idx];
    end else if (grp == GRP_DATA) begin
      if (idx == PIN_IDX_W'(IDX_IN))       rdata_o[NUM_PINS-1:0] = in_q;
      else if (idx == PIN_IDX_W'(IDX_OUT)) rdata_o[NUM_PINS-1:0] = out_q;
      else if (idx == PIN_IDX_W'(IDX_IRQ)) rdata_o[NUM_PINS-1:0] = irq_flags;
    end
  end

  assign pad_o    = out_q;
  assign pad_oe_o = oe_vec;
  assign irq_o    = |irq_flags;
endmodule

// File: rtl/gpio_bank_checker.sv
module gpio_bank_checker
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 32,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned PIN_IDX_W = $clog2(NUM_PINS),
  localparam int unsigned ADDR_W    = PIN_IDX_W + 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_en_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [DATA_W-1:0]   wdata_i,
  input logic [NUM_PINS-1:0] pad_o_i,
  input logic [NUM_PINS-1:0] pad_oe_i,
  input logic [NUM_PINS-1:0] in_q_i,
  input logic [NUM_PINS-1:0] in_en_i,
  input logic [NUM_PINS-1:0] out_en_i,
  input logic [NUM_PINS-1:0] int_en_i,
  input logic [NUM_PINS-1:0] irq_flags_i,
  input logic                irq_o_i
);
  logic cfg_wr_c, out_wr_c;
  assign cfg_wr_c = wr_en_i && addr_i[ADDR_W-1 -: 2] == GRP_CFG;
  assign out_wr_c = wr_en_i && addr_i == {GRP_DATA, PIN_IDX_W'(IDX_OUT)};

  p_out_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_wr_c |=> $stable(pad_o_i));

  p_out_mask_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_wr_c |=> ((pad_o_i ^ $past(pad_o_i)) & ~$past(out_en_i)) == '0);

  p_in_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((in_q_i ^ $past(in_q_i)) & ~$past(in_en_i)) == '0);

  p_oe_cfg_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_c |=> pad_oe_i[$past(addr_i[PIN_IDX_W-1:0])] == $past(wdata_i[CFG_OE]));

  p_int_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_flags_i & ~$past(irq_flags_i)) & ~$past(int_en_i)) == '0);

  p_irq_fall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o_i) |-> $past(wr_en_i));
endmodule

bind gpio_bank gpio_bank_checker #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .pad_o_i     (pad_o),
  .pad_oe_i    (pad_oe_o),
  .in_q_i      (in_q),
  .in_en_i     (in_en_vec),
  .out_en_i    (out_en_vec),
  .int_en_i    (int_en_vec),
  .irq_flags_i (irq_flags),
  .irq_o_i     (irq_o)
);

// File: tb/gpio_bank_bench.sv
module gpio_bank_bench;
  localparam int unsigned NP = 32;
  localparam logic [6:0] A_IN = 7'h20, A_OUT = 7'h21, A_IRQ = 7'h22;
  localparam int unsigned NVEC = 17;
  // {type[2:0], pad_before, pad_after, expected_flag}
  localparam logic [5:0] VEC [NVEC] = '{
    6'b000_0_0_0, 6'b000_0_1_1, 6'b000_1_0_1,
    6'b001_1_1_0, 6'b001_1_0_1, 6'b001_0_1_1,
    6'b010_0_1_1, 6'b010_1_0_0, 6'b010_1_1_0,
    6'b011_1_0_1, 6'b011_0_1_0,
    6'b100_0_1_1, 6'b100_1_0_1, 6'b100_0_0_0,
    6'b101_0_1_0, 6'b110_1_0_0, 6'b111_0_1_0
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [6:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] ext_pad = '0;
  logic [NP-1:0] pad_in, pad_out, pad_oe;
  logic          irq;
  int            n_tests = 0;
  int            n_fail = 0;
  logic [31:0]   v;

  always #10 clk = ~clk;

  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext_pad);

  gpio_bank u_gpio_bank (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .wr_en_i  (wr_en),
    .addr_i   (addr),
    .wdata_i  (wdata),
    .rdata_o  (rdata),
    .pad_i    (pad_in),
    .pad_o    (pad_out),
    .pad_oe_o (pad_oe),
    .irq_o    (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // call right after a negedge; reads are combinational
  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    rd(7'd0, v);  check("R1 cfg0", v, 32'h0);
    rd(7'd31, v); check("R1 cfg31", v, 32'h0);
    rd(A_IRQ, v); check("R1 flags", v, 32'h0);
    check("R1 pad_oe", pad_oe, 32'h0);
    check("R1 pad_o", pad_out, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);

    // R6 R7 R8 vector table
    for (int k = 0; k < NVEC; k++) begin
      automatic int pin = (k * 7) % NP;
      automatic logic [2:0] mt = VEC[k][5:3];
      wr(7'(pin), (32'(mt) << 5) | 32'h8);
      ext_pad[pin] = VEC[k][2];
      idle(4);
      wr(A_IRQ, 32'hFFFF_FFFF);
      ext_pad[pin] = VEC[k][1];
      idle(5);
      rd(A_IRQ, v);
      check(mt < 3'd2 ? "R6 level" : (mt < 3'd5 ? "R7 edge" : "R8 unused"),
            32'(v[pin]), 32'(VEC[k][0]));
      wr(7'(pin), 32'h0);
      ext_pad[pin] = 1'b0;
      idle(4);
      wr(A_IRQ, 32'hFFFF_FFFF);
    end

    // R11 reserved bits store only
    wr(7'd5, 32'hABCD_E010);
    idle(1);
    rd(7'd5, v); check("R11 readback", v, 32'hABCD_E010);
    check("R11 no oe", pad_oe, 32'h0);
    wr(7'd5, 32'h0);

    // R2 output register gating
    wr(A_OUT, 32'hFFFF_FFFF);
    idle(1);
    rd(A_OUT, v); check("R2 gated readback", v, 32'h0);
    check("R2 gated pad", pad_out, 32'h0);
    wr(7'd3, 32'h1);
    wr(A_OUT, 32'hFFFF_FFFF);
    idle(1);
    check("R2 enabled pad", pad_out, 32'h8);

    // R4 output enable
    wr(7'd3, 32'h5);
    check("R4 oe on", pad_oe, 32'h8);
    wr(7'd3, 32'h1);
    check("R4 oe off", pad_oe, 32'h0);

    // R3 capture latency and hold
    wr(7'd9, 32'h2);
    ext_pad[9] = 1'b1;
    idle(2);
    rd(A_IN, v); check("R3 not after 2 edges", 32'(v[9]), 32'h0);
    idle(1);
    rd(A_IN, v); check("R3 after 3 edges", 32'(v[9]), 32'h1);
    wr(7'd9, 32'h0);
    ext_pad[9] = 1'b0;
    idle(4);
    rd(A_IN, v); check("R3 hold when disabled", 32'(v[9]), 32'h1);

    // R13 bidirectional loopback
    wr(7'd12, 32'h7);
    wr(A_OUT, 32'h0000_1000);
    idle(4);
    rd(A_IN, v); check("R13 loop high", 32'(v[12]), 32'h1);
    wr(A_OUT, 32'h0);
    idle(4);
    rd(A_IN, v); check("R13 loop low", 32'(v[12]), 32'h0);
    wr(7'd12, 32'h0);

    // R5 interrupt disabled
    wr(7'd20, 32'h40);
    ext_pad[20] = 1'b1;
    idle(5);
    rd(A_IRQ, v); check("R5 flag", v, 32'h0);
    check("R5 irq", {31'h0, irq}, 32'h0);
    wr(7'd20, 32'h0);
    ext_pad[20] = 1'b0;
    idle(4);

    // R9 clear collides with live level
    wr(7'd1, 32'h8);
    ext_pad[1] = 1'b1;
    idle(4);
    wr(A_IRQ, 32'h2);
    rd(A_IRQ, v); check("R9 set wins", 32'(v[1]), 32'h1);
    ext_pad[1] = 1'b0;
    idle(4);
    wr(A_IRQ, 32'h0);
    rd(A_IRQ, v); check("R9 zero bit keeps", 32'(v[1]), 32'h1);
    wr(A_IRQ, 32'h2);
    rd(A_IRQ, v); check("R9 cleared", 32'(v[1]), 32'h0);
    wr(7'd1, 32'h0);

    // R10 combined line
    wr(7'd2, 32'h48);
    wr(7'd4, 32'h48);
    ext_pad[2] = 1'b1; ext_pad[4] = 1'b1;
    idle(5);
    check("R10 irq set", {31'h0, irq}, 32'h1);
    wr(A_IRQ, 32'h4);
    rd(A_IRQ, v); check("R10 one left", v, 32'h10);
    check("R10 irq still", {31'h0, irq}, 32'h1);
    wr(A_IRQ, 32'h10);
    check("R10 irq clear", {31'h0, irq}, 32'h0);

    // R12 unmapped group
    rd(7'h40, v); check("R12 unmapped", v, 32'h0);
    rd(7'h23, v); check("R12 unused index", v, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule